// File: doc/BRIEF.md
# Gate Driver Fault Controller

This block is the synchronous decision logic for one isolated power-switch gate driver. Two command inputs, one non-inverting and one inverting, are sampled on the clock. They are combined with a supply-undervoltage flag and a desaturation-comparator flag into a gate-drive level code. The gate is driven fully on only when the non-inverting command is high, the inverting command is low, the supply is healthy and no fault is held. Either command can therefore serve as the toggling control while the other is tied to its enabling level.

After each turn-on the desaturation flag is ignored for a blanking window. When the flag is seen during on-time after that window, the block does not cut the gate abruptly. It steps the drive-level code down to zero, latches a fault, pulls its open-drain fault line low and blocks the commands. Only an active-low fault-clear input releases the latch. That input acts asynchronously and works under undervoltage, and it never disturbs a gate that is on or a soft turn-off in progress. The analog comparators and the power stage sit outside the block. Both flags cross into the clock domain through two-flop synchronisers.

Top module: `gdrv_fault_ctrl`

## Requirements
- R1: `drive_level_o` is 7 (full on) only when the sampled non-inverting command is 1, the inverting command is 0, undervoltage is inactive and no fault is latched. It reaches 7 on the second rising clock edge after a qualifying command change and falls to 0 on the second edge after the command stops qualifying. Any other command pair, including non-inverting 0 with inverting 1, gives level 0.
- R2: Inverting use works with the non-inverting command held at 1: inverting 0 turns the gate on and inverting 1 turns it off, with the same two-edge latency.
- R3: `uv_i` at 1 forces level 0 on the third edge after it rises and never sets the fault. The gate comes back on the third edge after it falls if the command still qualifies.
- R4: The desaturation flag is acted on only while the gate is fully on and at least BLANK_CYC edges have passed since turn-on. A flag raised while the gate is off, or one that drops before blanking ends, changes nothing.
- R5: Soft turn-off sets the level to 6 on the detecting edge, then lowers it by one every STEP_CYC edges down to 0. `gate_on_o` stays 1 until the level is 0. Command changes during the sequence do not alter it.
- R6: On detection `fault_latched_o` and `fault_pd_o` go to 1 on the same edge. This is the third edge after the raw flag once blanking has ended, and always within FAULT_BOUND_CYC cycles. While the fault is latched the commands cannot turn the gate on.
- R7: `fault_clr_ni` at 0 clears the fault latch and `fault_pd_o` at once, without waiting for a clock edge, even while undervoltage is active. After release the commands drive the gate again.
- R8: Pulsing `fault_clr_ni` low while the gate is on leaves `drive_level_o` unchanged. Pulsing it during a soft turn-off leaves the stepping sequence unchanged.
- R9: `fault_pd_o` is the pull-down enable of an open-drain, active-low fault line, where 1 means pull low. Several controllers share one line as a wired-OR of their enables. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| cmd_pos_i | input | 1 | Non-inverting gate command |
| cmd_neg_i | input | 1 | Inverting gate command |
| uv_i | input | 1 | Supply-undervoltage flag, asynchronous |
| desat_i | input | 1 | Desaturation-comparator flag, asynchronous |
| fault_clr_ni | input | 1 | Active-low fault clear, asynchronous |
| drive_level_o | output | 3 | Gate-drive level code, 7 full on, 0 off |
| gate_on_o | output | 1 | Gate commanded above zero |
| fault_pd_o | output | 1 | Pull-down enable of the open-drain fault line |
| fault_latched_o | output | 1 | Fault latch status |

## Verification
Latencies are fixed and are counted from the clock edge at which a result is due. A command change shows at the drive level two edges later, one for the command sample and one for the state register. An undervoltage change needs three edges because it passes two synchroniser flops first. A desaturation detection lands BLANK_CYC+1 edges after the gate turned on, or three edges after the raw flag if blanking is already over, and every later soft step is STEP_CYC edges apart. The driver stamps each expected value with its due cycle. The monitor compares at the falling edge of exactly that cycle, and the asynchronous fault clear is checked directly a moment after the clear input falls.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  localparam int unsigned LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_FULL = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_SOFT0 = LVL_FULL - 1'b1;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_SOFT = 2'd2
  } drv_state_e;
endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
  import gdrv_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 200,
  parameter int unsigned STEP_CYC  = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_i,
  input  logic             desat_i,
  output logic [LVL_W-1:0] level_o,
  output logic             blank_done_o,
  output logic             desat_hit_o
);
  localparam int unsigned BLANK_W = $clog2(BLANK_CYC + 1);
  localparam int unsigned STEP_W  = $clog2(STEP_CYC + 1);

  drv_state_e       state_q;
  logic [BLANK_W-1:0] blank_q;
  logic [STEP_W-1:0]  step_q;
  logic [LVL_W-1:0]   level_q;

  assign blank_done_o = (blank_q == '0);
  assign desat_hit_o  = (state_q == ST_ON) && blank_done_o && desat_i;
  assign level_o      = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      level_q <= '0;
      blank_q <= '0;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_OFF: if (on_req_i) begin
          state_q <= ST_ON;
          level_q <= LVL_FULL;
          blank_q <= BLANK_W'(BLANK_CYC);
        end
        ST_ON: begin
          if (desat_hit_o) begin
            state_q <= ST_SOFT;
            level_q <= LVL_SOFT0;
            step_q  <= STEP_W'(STEP_CYC - 1);
          end else if (!on_req_i) begin
            state_q <= ST_OFF;
            level_q <= '0;
            blank_q <= '0;
          end else if (!blank_done_o) begin
            blank_q <= blank_q - 1'b1;
          end
        end
        ST_SOFT: begin
          // sequence runs to zero regardless of commands
          if (step_q == '0) begin
            level_q <= level_q - 1'b1;
            step_q  <= STEP_W'(STEP_CYC - 1);
            if (level_q == LVL_W'(1)) state_q <= ST_OFF;
          end else begin
            step_q <= step_q - 1'b1;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assert_no_hit_in_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && blank_q != '0) |=> (state_q != ST_SOFT));

  assert_soft_monotone_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT) |=> (level_q == $past(level_q) || level_q == ($past(level_q) - 3'd1)));

  assert_soft_not_interrupted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT && level_q != '0) |=> (state_q == ST_SOFT || level_q == '0));
endmodule

// File: rtl/gdrv_fault.sv
module gdrv_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic set_i,
  output logic latched_o
);
  logic clr_n;
  logic latch_q;

  assign clr_n = rst_ni & clr_ni;

  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n)     latch_q <= 1'b0;
    else if (set_i) latch_q <= 1'b1;
  end

  assign latched_o = latch_q;

  // only a desaturation hit may set the latch; undervoltage never does
  assert_fault_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(set_i));
endmodule

// File: rtl/gdrv_fault_ctrl.sv
module gdrv_fault_ctrl
  import gdrv_pkg::*;
#(
  parameter int unsigned BLANK_CYC       = 200,
  parameter int unsigned STEP_CYC        = 50,
  parameter int unsigned FAULT_BOUND_CYC = 500,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_pos_i,
  input  logic             cmd_neg_i,
  input  logic             uv_i,
  input  logic             desat_i,
  input  logic             fault_clr_ni,
  output logic [LVL_W-1:0] drive_level_o,
  output logic             gate_on_o,
  output logic             fault_pd_o,
  output logic             fault_latched_o
);
  localparam int unsigned PEND_W = $clog2(FAULT_BOUND_CYC + 1);

  logic uv_s, desat_s;
  logic cmd_pos_q, cmd_neg_q;
  logic on_req, blank_done, desat_hit, latched;

  gdrv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_uv_sync (
    .clk_i, .rst_ni, .d_i(uv_i), .q_o(uv_s)
  );
  gdrv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_desat_sync (
    .clk_i, .rst_ni, .d_i(desat_i), .q_o(desat_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_pos_q <= 1'b0;
      cmd_neg_q <= 1'b0;
    end else begin
      cmd_pos_q <= cmd_pos_i;
      cmd_neg_q <= cmd_neg_i;
    end
  end

  assign on_req = cmd_pos_q & ~cmd_neg_q & ~uv_s & ~latched;

  gdrv_seq #(.BLANK_CYC(BLANK_CYC), .STEP_CYC(STEP_CYC)) u_seq (
    .clk_i, .rst_ni,
    .on_req_i    (on_req),
    .desat_i     (desat_s),
    .level_o     (drive_level_o),
    .blank_done_o(blank_done),
    .desat_hit_o (desat_hit)
  );

  gdrv_fault u_fault (
    .clk_i, .rst_ni,
    .clr_ni   (fault_clr_ni),
    .set_i    (desat_hit),
    .latched_o(latched)
  );

  assign gate_on_o       = (drive_level_o != '0);
  assign fault_latched_o = latched;
  assign fault_pd_o      = latched;

  // cycles an eligible desaturation has waited without a latched fault
  logic [PEND_W-1:0] pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (drive_level_o == LVL_FULL && blank_done && desat_s && !latched) begin
      if (pend_q != {PEND_W{1'b1}}) pend_q <= pend_q + 1'b1;
    end else pend_q <= '0;
  end

  assert_fault_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q < PEND_W'(FAULT_BOUND_CYC));

  assert_gate_on_cond_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_on_o) |-> (!fault_latched_o && $past(cmd_pos_q && !cmd_neg_q && !uv_s)));

  assert_pd_follows_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_pd_o) |-> $past(gate_on_o));
endmodule

// File: tb/gdrv_fault_ctrl_bench.sv
module gdrv_fault_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 6;
  localparam int STEP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_pos = 1'b0, cmd_neg = 1'b0, uv = 1'b0, desat = 1'b0, clr_n = 1'b1;
  logic [2:0] level;
  logic gate_on, fault_pd, fault_lat;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [2:0] lvl;
    logic       flt;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gdrv_fault_ctrl #(.BLANK_CYC(BLANK), .STEP_CYC(STEP), .FAULT_BOUND_CYC(8)) u_gdrv_fault_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_pos_i(cmd_pos), .cmd_neg_i(cmd_neg),
    .uv_i(uv), .desat_i(desat), .fault_clr_ni(clr_n),
    .drive_level_o(level), .gate_on_o(gate_on), .fault_pd_o(fault_pd),
    .fault_latched_o(fault_lat)
  );

  task automatic chk(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic expect_at(input int dc, input logic [2:0] lvl, input logic flt, input string tag);
    q.push_back('{cyc + dc, lvl, flt, tag});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each item in its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      cur = q.pop_front();
      if (cur.at < cyc) chk({cur.tag, " missed slot"}, cyc, cur.at);
      else begin
        chk({cur.tag, " level"}, int'(level), int'(cur.lvl));
        chk({cur.tag, " gate_on"}, int'(gate_on), int'(cur.lvl != 3'd0));
        chk({cur.tag, " fault_pd"}, int'(fault_pd), int'(cur.flt));
        chk({cur.tag, " latched"}, int'(fault_lat), int'(cur.flt));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    chk("R9 reset fault_pd", int'(fault_pd), 0);
    chk("R1 reset level", int'(level), 0);
    step(4);

    // R1 non-inverting use (also R2 by symmetry)
    cmd_pos = 1'b1;
    expect_at(1, 3'd0, 1'b0, "R1 on sample");
    expect_at(2, 3'd7, 1'b0, "R1 on");
    step(4);
    cmd_pos = 1'b0;
    expect_at(1, 3'd7, 1'b0, "R1 off sample");
    expect_at(2, 3'd0, 1'b0, "R1 off");
    step(4);

    // R2 inverting use
    cmd_pos = 1'b1; cmd_neg = 1'b1;
    expect_at(2, 3'd0, 1'b0, "R2 neg high off");
    step(4);
    cmd_neg = 1'b0;
    expect_at(2, 3'd7, 1'b0, "R2 neg low on");
    step(4);
    cmd_neg = 1'b1;
    expect_at(2, 3'd0, 1'b0, "R2 neg high again");
    step(4);
    cmd_pos = 1'b0; cmd_neg = 1'b1;
    expect_at(3, 3'd0, 1'b0, "R1 illegal pair");
    step(4);
    cmd_neg = 1'b0;
    step(2);

    // R3 undervoltage lockout
    cmd_pos = 1'b1;
    expect_at(2, 3'd7, 1'b0, "R3 pre on");
    step(4);
    uv = 1'b1;
    expect_at(2, 3'd7, 1'b0, "R3 uv latency");
    expect_at(3, 3'd0, 1'b0, "R3 uv off");
    expect_at(8, 3'd0, 1'b0, "R3 uv no fault");
    step(8);
    uv = 1'b0;
    expect_at(2, 3'd0, 1'b0, "R3 uv release latency");
    expect_at(3, 3'd7, 1'b0, "R3 uv release on");
    step(4);
    cmd_pos = 1'b0;
    step(4);

    // R4 desat while off
    desat = 1'b1;
    expect_at(6, 3'd0, 1'b0, "R4 desat while off");
    step(7);
    desat = 1'b0;
    step(3);

    // R4 desat confined to blanking window
    cmd_pos = 1'b1; desat = 1'b1;
    expect_at(2, 3'd7, 1'b0, "R4 on in blank");
    step(4);
    desat = 1'b0;
    expect_at(8, 3'd7, 1'b0, "R4 blanked pulse ignored");
    step(9);
    cmd_pos = 1'b0;
    step(4);

    // R5/R6 desat after blanking -> soft off and latch
    cmd_pos = 1'b1; desat = 1'b1;
    expect_at(BLANK + 2, 3'd7, 1'b0, "R4 end of blank");
    expect_at(BLANK + 3, 3'd6, 1'b1, "R6 detect latch");
    expect_at(BLANK + 3 + STEP - 1, 3'd6, 1'b1, "R5 hold step");
    for (int j = 1; j <= 6; j++)
      expect_at(BLANK + 3 + STEP * j, 3'(6 - j), 1'b1, "R5 soft step");
    expect_at(BLANK + 3 + STEP * 6 + 5, 3'd0, 1'b1, "R6 inputs blocked");
    step(11);
    cmd_pos = 1'b0; desat = 1'b0;
    step(3);
    cmd_pos = 1'b1;
    step(26);

    // R7 async clear
    cmd_pos = 1'b0;
    step(3);
    clr_n = 1'b0;
    #1;
    chk("R7 async clear pd", int'(fault_pd), 0);
    chk("R7 async clear latch", int'(fault_lat), 0);
    step(1);
    clr_n = 1'b1;
    cmd_pos = 1'b1;
    expect_at(2, 3'd7, 1'b0, "R7 re-enabled");
    step(4);

    // R8 clear while gate on
    clr_n = 1'b0;
    expect_at(1, 3'd7, 1'b0, "R8 clear gate on");
    step(1);
    clr_n = 1'b1;
    expect_at(1, 3'd7, 1'b0, "R8 clear gate on after");
    step(2);
    cmd_pos = 1'b0;
    step(4);

    // R8 clear during soft turn-off
    cmd_pos = 1'b1; desat = 1'b1;
    expect_at(BLANK + 3, 3'd6, 1'b1, "R6 second detect");
    step(BLANK + 3 + STEP - 1);
    desat = 1'b0; cmd_pos = 1'b0; clr_n = 1'b0;
    expect_at(1, 3'd5, 1'b0, "R8 soft continues");
    expect_at(1 + STEP, 3'd4, 1'b0, "R8 soft continues 2");
    expect_at(1 + STEP * 5 + 1, 3'd0, 1'b0, "R5 soft done");
    step(1);
    clr_n = 1'b1;
    step(STEP * 5 + 3);

    // R7 clear under undervoltage
    cmd_pos = 1'b1; desat = 1'b1;
    expect_at(BLANK + 3, 3'd6, 1'b1, "R6 third detect");
    expect_at(BLANK + 3 + STEP * 6 + 6, 3'd0, 1'b1, "R6 held under uv");
    step(BLANK + 4);
    uv = 1'b1; desat = 1'b0; cmd_pos = 1'b0;
    step(STEP * 6 + 8);
    clr_n = 1'b0;
    #1;
    chk("R7 clear under uv", int'(fault_lat), 0);
    step(1);
    clr_n = 1'b1;
    cmd_pos = 1'b1;
    expect_at(3, 3'd0, 1'b0, "R3 uv still blocks");
    step(4);
    uv = 1'b0;
    expect_at(3, 3'd7, 1'b0, "R7 on after uv clear");
    step(4);
    cmd_pos = 1'b0;
    step(4);

    done = 1'b1;
    if (q.size() != 0) chk("queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule